// File: doc/BRIEF.md
# Fractional-Rate Complex Quadrature Modulator

This block moves a complex baseband stream up or down in frequency. It sits after an 8x interpolator and runs at the output sample rate. Each accepted I/Q pair is multiplied by a complex carrier cos(θ) + j·sin(θ), which gives I' = I·cos − Q·sin and Q' = I·sin + Q·cos. The carrier frequency is k·fDAC/8, where k is a signed index. An optional flag adds a further fDAC/16, which is half the input data rate. With the flag set, the passband centre can sit in the middle of an input Nyquist zone.

The phase comes from a 4-bit counter that wraps modulo 16, and a sixteen-point sine/cosine table at 22.5° steps supplies the coefficients. The counter advances once for every accepted sample. The carrier setting is latched only while reset is low or on a sync pulse, and both of those events also return the phase to zero. The result is rounded, saturated back to the input width and presented two clocks after the input, with its own valid strobe.

Top module: `cplx_shift_mod`

## Requirements
- R1: For each accepted sample, out_i = sat(round(I·C − Q·S)) and out_q = sat(round(I·S + Q·C)). The products are scaled by 2^-15. Rounding is to nearest with halves rounded upward (add 2^14, then arithmetic shift right by 15). Saturation limits the result to the signed 16-bit range.
- R2: mode_k_i is a 3-bit two's-complement carrier index k in −4..3 that selects a carrier of k·fDAC/8, and −4 means fDAC/2. With mode_half_i low, the phase index moves by 2k modulo 16 per accepted sample.
- R3: With mode_half_i high, the phase index moves by 2k+1 modulo 16 per accepted sample, which adds fDAC/16 to the carrier.
- R4: For phase index n, S = round(32768·sin(n·π/8)) and C is the S value at index n+4. A value of +32768 is replaced by 32767, and −1.0 becomes −32768.
- R5: out_valid_o equals in_valid_i delayed by exactly two clocks, and the data on the outputs belongs to that delayed sample.
- R6: mode_k_i and mode_half_i are sampled only in a cycle where rst_n is low or sync_i is high. Changes to them in any other cycle have no effect on the outputs.
- R7: In a cycle with sync_i high, the phase index becomes 0, and the next accepted sample uses phase 0. A sample accepted in the sync cycle itself still uses the old phase.
- R8: The phase index changes only in cycles where in_valid_i is high or sync_i is high.
- R9: While out_valid_o is low, out_i_o and out_q_o keep their previous values.
- R10: After a clock with rst_n low, out_valid_o, out_i_o and out_q_o are 0 and the phase index is 0.
- R11: With k = 0 and mode_half_i low, every sample uses C = 32767 and S = 0. Each output is therefore its input scaled by 32767/32768, rounded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output-rate clock |
| rst_n | input | 1 | Synchronous active-low reset; also latches the carrier setting |
| sync_i | input | 1 | Latches the carrier setting and clears the phase |
| mode_k_i | input | 3 | Signed carrier index k (carrier = k·fDAC/8) |
| mode_half_i | input | 1 | Adds fDAC/16 to the carrier when high |
| in_valid_i | input | 1 | Input sample strobe |
| in_i_i | input | DW | Signed in-phase input sample |
| in_q_i | input | DW | Signed quadrature input sample |
| out_valid_o | output | 1 | Output sample strobe, two clocks after in_valid_i |
| out_i_o | output | DW | Rotated in-phase result |
| out_q_o | output | DW | Rotated quadrature result |

## Verification
The assertions assume that rst_n is held low for at least one clock before any check matters. They also assume that in_valid_i, sync_i and the mode pins carry known values at every clock edge after that reset. The stimulus keeps every input driven at all times, with no X or Z, and changes inputs only on the falling edge. After reset, the mode pins move freely without sync_i to test R6, and valid gaps and mid-stream syncs are placed so that every phase-hold and output-hold rule is exercised.

// File: rtl/cqm_pkg.sv
// Package: constants and the quarter-wave coefficient function for the
// complex quadrature modulator. Assumes a 16-point carrier phase circle.
package cqm_pkg;
    localparam int PH_W   = 4;            // phase index bits (16 phases)
    localparam int COEF_W = 16;           // Q1.15 coefficient width
    localparam int QTR    = 1 << (PH_W - 2);

    // Sine of phase index n (n * 22.5 degrees) in Q1.15, unity saturated.
    function automatic logic signed [COEF_W-1:0] sin_q15(input logic [PH_W-1:0] n);
        logic [2:0]               m;
        logic signed [COEF_W-1:0] mag;
        m = n[PH_W-2] ? (3'(QTR) - {1'b0, n[PH_W-3:0]}) : {1'b0, n[PH_W-3:0]};
        case (m)
            3'd0:    mag = 16'sd0;
            3'd1:    mag = 16'sd12540;
            3'd2:    mag = 16'sd23170;
            3'd3:    mag = 16'sd30274;
            default: mag = 16'sd32767;
        endcase
        if (n[PH_W-1]) begin
            sin_q15 = (m == 3'(QTR)) ? -16'sd32768 : -mag;
        end else begin
            sin_q15 = mag;
        end
    endfunction
endpackage

// File: rtl/qm_phase_acc.sv
// Phase accumulator: a PW-bit counter that wraps naturally.
// Assumes step_i is held steady by the caller between clears.
module qm_phase_acc #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          adv_i,
    input  logic [PW-1:0] step_i,
    output logic [PW-1:0] phase_o
);
    // Clear on reset or sync, otherwise advance on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            phase_o <= '0;
        end else if (adv_i) begin
            phase_o <= phase_o + step_i;
        end
    end
endmodule

// File: rtl/qm_cmul.sv
// Complex multiply stage: registers the four partial products of the
// sample with the carrier. Assumes signed two's-complement operands.
module qm_cmul #(
    parameter int DW = 16,
    parameter int CW = 16,
    localparam int PW = DW + CW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic signed [DW-1:0] a_i,
    input  logic signed [DW-1:0] b_i,
    input  logic signed [CW-1:0] cos_i,
    input  logic signed [CW-1:0] sin_i,
    output logic                 valid_o,
    output logic signed [PW-1:0] p_ac_o,
    output logic signed [PW-1:0] p_bs_o,
    output logic signed [PW-1:0] p_as_o,
    output logic signed [PW-1:0] p_bc_o
);
    // Delay the valid strobe by one stage.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else        valid_o <= valid_i;
    end

    // Capture the products only for accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_ac_o <= '0;
            p_bs_o <= '0;
            p_as_o <= '0;
            p_bc_o <= '0;
        end else if (valid_i) begin
            p_ac_o <= a_i * cos_i;
            p_bs_o <= b_i * sin_i;
            p_as_o <= a_i * sin_i;
            p_bc_o <= b_i * cos_i;
        end
    end
endmodule

// File: rtl/qm_rnd_sat.sv
// Combine, round and saturate stage: forms I and Q sums, rounds half-up at
// bit CW-1 and clamps to DW bits. Outputs hold when no sample is present.
module qm_rnd_sat #(
    parameter int DW = 16,
    parameter int CW = 16,
    localparam int PW = DW + CW,
    localparam int SW = PW + 1,
    localparam int RW = SW - (CW - 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic signed [PW-1:0] p_ac_i,
    input  logic signed [PW-1:0] p_bs_i,
    input  logic signed [PW-1:0] p_as_i,
    input  logic signed [PW-1:0] p_bc_i,
    output logic                 valid_o,
    output logic signed [DW-1:0] i_o,
    output logic signed [DW-1:0] q_o
);
    localparam logic signed [SW-1:0] HALF = SW'(1) << (CW - 2);
    localparam logic signed [RW-1:0] MAXV = {{(RW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [RW-1:0] MINV = ~MAXV;

    // Round a full-precision sum to nearest and clamp it to DW bits.
    function automatic logic signed [DW-1:0] fold(input logic signed [SW-1:0] s);
        logic signed [SW-1:0] t;
        logic signed [RW-1:0] r;
        t = s + HALF;
        r = RW'(t >>> (CW - 1));
        if (r > MAXV)      fold = MAXV[DW-1:0];
        else if (r < MINV) fold = MINV[DW-1:0];
        else               fold = r[DW-1:0];
    endfunction

    logic signed [SW-1:0] sum_i, sum_q;

    // Form the rotated sums at full precision.
    always_comb begin
        sum_i = SW'(p_ac_i) - SW'(p_bs_i);
        sum_q = SW'(p_as_i) + SW'(p_bc_i);
    end

    // Register the rounded results and the matching strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            i_o     <= '0;
            q_o     <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                i_o <= fold(sum_i);
                q_o <= fold(sum_q);
            end
        end
    end
endmodule

// File: rtl/cplx_shift_mod.sv
// Top: complex quadrature modulator at the output rate. The carrier is
// k*fDAC/8 plus an optional fDAC/16. The carrier setting is latched on reset
// or sync, and either event clears the phase. Assumes a 16-point phase circle.
module cplx_shift_mod
    import cqm_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync_i,
    input  logic [2:0]           mode_k_i,
    input  logic                 mode_half_i,
    input  logic                 in_valid_i,
    input  logic signed [DW-1:0] in_i_i,
    input  logic signed [DW-1:0] in_q_i,
    output logic                 out_valid_o,
    output logic signed [DW-1:0] out_i_o,
    output logic signed [DW-1:0] out_q_o
);
    localparam int PW = DW + COEF_W;

    logic [PH_W-1:0]          step_q;
    logic [PH_W-1:0]          phase_w;
    logic signed [COEF_W-1:0] cos_w, sin_w;
    logic                     v1_w;
    logic signed [PW-1:0]     p_ac_w, p_bs_w, p_as_w, p_bc_w;

    // Latch the phase step (2k + half) only on reset or sync.
    always_ff @(posedge clk) begin
        if (!rst_n || sync_i) begin
            step_q <= {mode_k_i, mode_half_i};
        end
    end

    qm_phase_acc #(.PW(PH_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (sync_i),
        .adv_i   (in_valid_i),
        .step_i  (step_q),
        .phase_o (phase_w)
    );

    // Look up the carrier; cosine is sine a quarter turn ahead.
    always_comb begin
        sin_w = sin_q15(phase_w);
        cos_w = sin_q15(phase_w + PH_W'(QTR));
    end

    qm_cmul #(.DW(DW), .CW(COEF_W)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (in_valid_i),
        .a_i     (in_i_i),
        .b_i     (in_q_i),
        .cos_i   (cos_w),
        .sin_i   (sin_w),
        .valid_o (v1_w),
        .p_ac_o  (p_ac_w),
        .p_bs_o  (p_bs_w),
        .p_as_o  (p_as_w),
        .p_bc_o  (p_bc_w)
    );

    qm_rnd_sat #(.DW(DW), .CW(COEF_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (v1_w),
        .p_ac_i  (p_ac_w),
        .p_bs_i  (p_bs_w),
        .p_as_i  (p_as_w),
        .p_bc_i  (p_bc_w),
        .valid_o (out_valid_o),
        .i_o     (out_i_o),
        .q_o     (out_q_o)
    );
endmodule

// File: rtl/cplx_shift_mod_chk.sv
// Checker for cplx_shift_mod: timing, mode latching and hold rules.
// Assumes reset is applied before the first checked cycle.
module cplx_shift_mod_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sync_i,
    input logic          in_valid_i,
    input logic          out_valid_o,
    input logic [DW-1:0] out_i_o,
    input logic [DW-1:0] out_q_o,
    input logic [3:0]    ph,
    input logic [3:0]    step
);
    logic [1:0] age_q;

    // Count clocks since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)              age_q <= '0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    // R5
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (out_valid_o == $past(in_valid_i, 2)));

    // R7
    sync_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (ph == 4'd0));

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && !sync_i) |=> $stable(step));

    // R8
    ph_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && !in_valid_i && !sync_i) |=> $stable(ph));

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && !out_valid_o) |-> ($stable(out_i_o) && $stable(out_q_o)));
endmodule

bind cplx_shift_mod cplx_shift_mod_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_i      (sync_i),
    .in_valid_i  (in_valid_i),
    .out_valid_o (out_valid_o),
    .out_i_o     (out_i_o),
    .out_q_o     (out_q_o),
    .ph          (phase_w),
    .step        (step_q)
);

// File: tb/cplx_shift_mod_bench.sv
// Bench: a behavioural model with a two-entry expected pipeline, compared
// against the outputs on every clock.
module cplx_shift_mod_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_i = 1'b0;
    logic [2:0] mode_k_i = 3'd0;
    logic mode_half_i = 1'b0;
    logic in_valid_i = 1'b0;
    logic signed [15:0] in_i_i = '0, in_q_i = '0;
    logic out_valid_o;
    logic signed [15:0] out_i_o, out_q_o;

    int errors = 0, checks = 0, cycles = 0;
    int mph = 0, mstep = 0;
    bit p1_v = 0, eo_v = 0;
    int p1_i = 0, p1_q = 0, eo_i = 0, eo_q = 0;

    cplx_shift_mod u_cplx_shift_mod (.*);

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    function automatic int coef(input int n);
        real x;
        longint r;
        x = $sin(3.14159265358979 * real'(n % 16) / 8.0) * 32768.0;
        r = longint'($floor(x + 0.5));
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    function automatic int rsat(input longint s);
        longint r;
        r = (s + 64'sd16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    function automatic int rnd16();
        return int'($urandom_range(0, 65535)) - 32768;
    endfunction

    // One clock: drive at negedge, update the model at posedge, compare after.
    task automatic tick(input bit v, input int ii, input int qq, input bit sy,
                        input int k, input bit h, input string tag);
        longint c, s;
        int ni, nq;
        sync_i = sy; in_valid_i = v; mode_k_i = 3'(k); mode_half_i = h;
        in_i_i = 16'(ii); in_q_i = 16'(qq);
        c = coef(mph + 4); s = coef(mph);
        ni = rsat(longint'(ii) * c - longint'(qq) * s);
        nq = rsat(longint'(ii) * s + longint'(qq) * c);
        @(posedge clk);
        if (!rst_n) begin
            eo_v = 0; eo_i = 0; eo_q = 0; p1_v = 0;
            mph = 0; mstep = ((k & 7) << 1) | h;
        end else begin
            eo_v = p1_v;
            if (p1_v) begin eo_i = p1_i; eo_q = p1_q; end
            p1_v = v; p1_i = ni; p1_q = nq;
            if (sy) begin mph = 0; mstep = ((k & 7) << 1) | h; end
            else if (v) mph = (mph + mstep) % 16;
        end
        @(negedge clk);
        checks++;
        if (out_valid_o !== eo_v || int'(out_i_o) != eo_i || int'(out_q_o) != eo_q) begin
            errors++;
            $display("FAIL %s: actual v=%0b i=%0d q=%0d expected v=%0b i=%0d q=%0d",
                     tag, out_valid_o, out_i_o, out_q_o, eo_v, eo_i, eo_q);
        end
    endtask

    initial begin
        int tv[6] = '{32767, -32768, 1, -1, 0, 12345};
        @(negedge clk);
        // R10: reset state, with inputs active.
        for (int n = 0; n < 3; n++) tick(1, 1000, -1000, 0, 0, 0, "R10");
        rst_n = 1'b1;
        // R11: pass-through with k=0, including extremes.
        for (int n = 0; n < 6; n++) tick(1, tv[n], tv[5 - n], 0, 0, 0, "R11");
        for (int n = 0; n < 20; n++) tick(1, rnd16(), rnd16(), 0, 0, 0, "R11");
        // R1 R2 R3 R4: every carrier index, plain and shifted.
        for (int k = -4; k < 4; k++) begin
            for (int h = 0; h < 2; h++) begin
                tick(0, 0, 0, 1, k, bit'(h), h ? "R3" : "R2");
                tick(1, 32767, -32768, 0, k, bit'(h), "R4");
                tick(1, -32768, -32768, 0, k, bit'(h), "R4");
                for (int n = 0; n < 20; n++)
                    tick(1, rnd16(), rnd16(), 0, k, bit'(h), h ? "R1 R3" : "R1 R2");
            end
        end
        // R5 R8 R9: gaps in the input strobe.
        tick(0, 0, 0, 1, 1, 1, "R7");
        for (int n = 0; n < 30; n++)
            tick(bit'((n % 3) != 1), rnd16(), rnd16(), 0, 1, 1, "R5 R8 R9");
        // R6: mode pins move without sync and must be ignored.
        for (int n = 0; n < 16; n++)
            tick(1, rnd16(), rnd16(), 0, (n % 8) - 4, bit'(n % 2), "R6");
        // R7: sync during a valid stream; the sync-cycle sample uses old phase.
        for (int n = 0; n < 5; n++) tick(1, rnd16(), rnd16(), 0, 3, 0, "R7");
        tick(1, 20000, -7000, 1, 3, 0, "R7");
        for (int n = 0; n < 10; n++) tick(1, rnd16(), rnd16(), 0, 3, 0, "R7");
        for (int n = 0; n < 4; n++) tick(0, 0, 0, 0, 3, 0, "R5 R9");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule